// File: doc/BRIEF.md
# Iterative XOR-chain and half-block arithmetic cipher core

This core scrambles or restores one data block at a time. A block is a vector of `BLK_W` bits, where bit 0 is the least significant bit. The core has two stages. The chain stage runs a running-parity pass over the block, so that every bit absorbs all the bits before it in the chosen direction. The arithmetic stage treats the block as two halves and adds one half into the other, modulo 2^(BLK_W/2).

Encryption runs the chain stage `m` times and then the arithmetic stage `a` times. Decryption undoes both stages in reverse order. It first runs `a` subtractions. It then runs `BLK_W - m` further chain passes, which brings the block back to its original value when `BLK_W` is a power of two. A two-bit option sets the direction of each stage.

A caller loads the block, the mode, the option and the two counts with a one-cycle start strobe. The core then runs one pass per clock. It raises a one-cycle completion pulse and holds the result until the next accepted start.

Top module: `chain_cipher_core`

## Requirements
- R1: A forward chain pass leaves bit 0 unchanged and sets each bit j ≥ 1 to the new bit j−1 XOR the old bit j.
- R2: A backward chain pass leaves bit BLK_W−1 unchanged and sets each bit j < BLK_W−1 to the new bit j+1 XOR the old bit j.
- R3: In encryption the core runs `xor_cnt` chain passes and then `add_cnt` addition passes. The low half is bits [BLK_W/2−1:0] and the high half is the rest. A forward addition sets high = high + low, and a backward addition sets low = low + high, both modulo 2^(BLK_W/2).
- R4: In decryption the core first runs `add_cnt` subtraction passes: forward sets high = high − low, backward sets low = low − high. It then runs BLK_W − `xor_cnt` chain passes, or none when `xor_cnt` is 0. Decrypting an encrypted block with the same option and counts returns the original block.
- R5: `opt[1]` selects the chain direction and `opt[0]` selects the arithmetic direction, with 0 meaning forward and 1 meaning backward. `mode` 0 selects encryption and 1 selects decryption.
- R6: The core runs one pass per clock. Let P be the total number of passes. `done` is high for exactly one cycle, and it is set by the (P+1)-th rising edge after the edge that captures `start`.
- R7: After a synchronous reset, `blk_out` is 0 and `done` is 0. The result stays on `blk_out` from the done pulse until the next accepted start.
- R8: A `start` that arrives between the capturing edge and the done edge is ignored. The running operation's inputs, result and done timing are unchanged.
- R9: A count of zero skips that stage. With both counts zero, `done` follows on the next edge and `blk_out` equals the input block.
- R10: With BLK_W = 8, input 8'h59, option 00 and three forward chain passes with no additions, the result is 8'h5B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; captures all operands when idle |
| mode | input | 1 | 0 encrypt, 1 decrypt |
| opt | input | 2 | Stage directions: bit 1 chain, bit 0 arithmetic |
| xor_cnt | input | $clog2(BLK_W) | Chain pass count m (the encryption value, in both modes) |
| add_cnt | input | ACNT_W | Arithmetic pass count |
| blk_in | input | BLK_W | Block to process |
| blk_out | output | BLK_W | Result block |
| done | output | 1 | One-cycle completion pulse |

## Verification
A remaining-pass counter that is wrong by one shows up at the ports at once as a done pulse one cycle early or late, because the bench checks `done` on every clock against the pass count it expects. A wrong direction or a swapped half corrupts `blk_out` at the done cycle of that same operation. A single wrong bit in a chain pass spreads to every later bit, so it cannot stay hidden. Running decryption on encryption's output catches any error that only breaks the inverse. A busy-time start that is wrongly accepted changes both the result and the done timing within one operation.

// File: rtl/chain_cipher_pkg.sv
package chain_cipher_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CHAIN = 2'd1,
        OP_ARITH = 2'd2
    } pass_op_e;

    typedef struct packed {
        logic chain_bwd;
        logic arith_bwd;
    } stage_dir_t;

    localparam logic MODE_ENC = 1'b0;
    localparam logic MODE_DEC = 1'b1;

    function automatic stage_dir_t decode_opt(input logic [1:0] o);
        stage_dir_t d;
        d.chain_bwd = o[1];
        d.arith_bwd = o[0];
        return d;
    endfunction

endpackage

// File: rtl/xchain_pass.sv
module xchain_pass #(
    parameter int W = 64
) (
    input  logic [W-1:0] din,
    input  logic         bwd,
    output logic [W-1:0] dout
);
    logic [W-1:0] fwd_v;
    logic [W-1:0] bwd_v;

    always_comb begin
        fwd_v[0] = din[0];
        for (int j = 1; j < W; j++) begin
            fwd_v[j] = fwd_v[j-1] ^ din[j];
        end
    end

    always_comb begin
        bwd_v[W-1] = din[W-1];
        for (int j = W - 2; j >= 0; j--) begin
            bwd_v[j] = bwd_v[j+1] ^ din[j];
        end
    end

    assign dout = bwd ? bwd_v : fwd_v;
endmodule

// File: rtl/half_arith_pass.sv
module half_arith_pass #(
    parameter int W = 64
) (
    input  logic [W-1:0] din,
    input  logic         bwd,
    input  logic         sub,
    output logic [W-1:0] dout
);
    localparam int H = W / 2;

    logic [H-1:0] lo, hi, tgt, src, res;

    assign lo  = din[H-1:0];
    assign hi  = din[W-1:H];
    assign tgt = bwd ? lo : hi;
    assign src = bwd ? hi : lo;
    assign res = sub ? (tgt - src) : (tgt + src);

    generate
        if (W % 2 == 0) begin : g_even
            assign dout = bwd ? {hi, res} : {res, lo};
        end else begin : g_odd
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/pass_sequencer.sv
module pass_sequencer
    import chain_cipher_pkg::*;
#(
    parameter int W      = 64,
    parameter int XCNT_W = 6,
    parameter int ACNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode,
    input  logic [1:0]        opt,
    input  logic [XCNT_W-1:0] xor_cnt,
    input  logic [ACNT_W-1:0] add_cnt,
    output logic              load,
    output pass_op_e          op,
    output stage_dir_t        dir,
    output logic              sub,
    output logic              done
);
    localparam int XR_W  = XCNT_W + 1;
    localparam int TOT_W = ((XR_W > ACNT_W) ? XR_W : ACNT_W) + 1;

    seq_state_e        state;
    logic              mode_q;
    stage_dir_t        dir_q;
    logic [XR_W-1:0]   xrem;
    logic [ACNT_W-1:0] arem;
    logic [XR_W-1:0]   xload;

    assign load = start && (state == ST_IDLE);

    always_comb begin
        if (mode == MODE_DEC && xor_cnt != '0)
            xload = XR_W'(W) - {1'b0, xor_cnt};
        else if (mode == MODE_DEC)
            xload = '0;
        else
            xload = {1'b0, xor_cnt};
    end

    always_comb begin
        op = OP_HOLD;
        if (state == ST_RUN) begin
            if (mode_q == MODE_ENC) begin
                if (xrem != '0)      op = OP_CHAIN;
                else if (arem != '0) op = OP_ARITH;
            end else begin
                if (arem != '0)      op = OP_ARITH;
                else if (xrem != '0) op = OP_CHAIN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            mode_q <= MODE_ENC;
            dir_q  <= '0;
            xrem   <= '0;
            arem   <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                state  <= ST_RUN;
                mode_q <= mode;
                dir_q  <= decode_opt(opt);
                xrem   <= xload;
                arem   <= add_cnt;
            end else if (state == ST_RUN) begin
                case (op)
                    OP_CHAIN: xrem <= xrem - 1'b1;
                    OP_ARITH: arem <= arem - 1'b1;
                    default: begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign dir = dir_q;
    assign sub = mode_q;

    logic [TOT_W-1:0] total;
    assign total = TOT_W'(xrem) + TOT_W'(arem);

    // R6
    count_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && op != OP_HOLD) |=> (total == $past(total) - 1'b1));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && start) |=> ($stable(mode_q) && $stable(dir_q)));
endmodule

// File: rtl/chain_cipher_core.sv
module chain_cipher_core
    import chain_cipher_pkg::*;
#(
    parameter int  BLK_W  = 64,
    parameter int  ACNT_W = 8,
    localparam int XCNT_W = $clog2(BLK_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode,
    input  logic [1:0]        opt,
    input  logic [XCNT_W-1:0] xor_cnt,
    input  logic [ACNT_W-1:0] add_cnt,
    input  logic [BLK_W-1:0]  blk_in,
    output logic [BLK_W-1:0]  blk_out,
    output logic              done
);
    localparam int H = BLK_W / 2;

    logic             load;
    pass_op_e         op;
    stage_dir_t       dir;
    logic             sub;
    logic [BLK_W-1:0] data_q;
    logic [BLK_W-1:0] chain_out;
    logic [BLK_W-1:0] arith_out;

    pass_sequencer #(.W(BLK_W), .XCNT_W(XCNT_W), .ACNT_W(ACNT_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .opt(opt),
        .xor_cnt(xor_cnt), .add_cnt(add_cnt),
        .load(load), .op(op), .dir(dir), .sub(sub), .done(done)
    );

    xchain_pass #(.W(BLK_W)) u_chain (
        .din(data_q), .bwd(dir.chain_bwd), .dout(chain_out)
    );

    half_arith_pass #(.W(BLK_W)) u_arith (
        .din(data_q), .bwd(dir.arith_bwd), .sub(sub), .dout(arith_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= blk_in;
        end else begin
            case (op)
                OP_CHAIN: data_q <= chain_out;
                OP_ARITH: data_q <= arith_out;
                default:  data_q <= data_q;
            endcase
        end
    end

    assign blk_out = data_q;

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD && !load) |=> $stable(data_q));

    // R1
    fwd_lsb_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CHAIN && !dir.chain_bwd && !load) |=> (data_q[0] == $past(data_q[0])));

    // R2
    bwd_msb_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CHAIN && dir.chain_bwd && !load) |=> (data_q[BLK_W-1] == $past(data_q[BLK_W-1])));

    // R3
    arith_src_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ARITH && !dir.arith_bwd && !load) |=> (data_q[H-1:0] == $past(data_q[H-1:0])));
endmodule

// File: tb/sim_chain_cipher_core.sv
module sim_chain_cipher_core;
    localparam int N  = 64;
    localparam int XW = 6;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          start = 1'b0, mode = 1'b0;
    logic [1:0]    opt = '0;
    logic [XW-1:0] xc = '0;
    logic [AW-1:0] ac = '0;
    logic [N-1:0]  blk = '0;
    logic [N-1:0]  res;
    logic          done;

    logic          s8 = 1'b0;
    logic [2:0]    xc8 = '0;
    logic [7:0]    blk8 = '0;
    logic [7:0]    res8;
    logic          done8;

    int checks = 0;
    int fails  = 0;

    chain_cipher_core #(.BLK_W(N), .ACNT_W(AW)) u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .opt(opt),
        .xor_cnt(xc), .add_cnt(ac), .blk_in(blk), .blk_out(res), .done(done)
    );

    chain_cipher_core #(.BLK_W(8), .ACNT_W(4)) u1 (
        .clk(clk), .rst(rst), .start(s8), .mode(1'b0), .opt(2'b00),
        .xor_cnt(xc8), .add_cnt(4'd0), .blk_in(blk8), .blk_out(res8), .done(done8)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] ref_chain(input logic [N-1:0] v, input bit bwd);
        logic [N-1:0] r = v;
        if (!bwd) for (int j = 1; j < N; j++) r[j] = r[j-1] ^ v[j];
        else      for (int j = N - 2; j >= 0; j--) r[j] = r[j+1] ^ v[j];
        return r;
    endfunction

    function automatic logic [N-1:0] ref_arith(input logic [N-1:0] v, input bit bwd, input bit dec);
        logic [31:0] lo = v[31:0];
        logic [31:0] hi = v[63:32];
        if (!bwd) hi = dec ? hi - lo : hi + lo;
        else      lo = dec ? lo - hi : lo + hi;
        return {hi, lo};
    endfunction

    function automatic int chain_runs(input bit dec, input int m);
        if (!dec) return m;
        return (m == 0) ? 0 : N - m;
    endfunction

    function automatic logic [N-1:0] ref_cipher(input logic [N-1:0] v, input bit dec,
                                                input logic [1:0] o, input int m, input int a);
        logic [N-1:0] r = v;
        int xr = chain_runs(dec, m);
        if (!dec) begin
            for (int i = 0; i < xr; i++) r = ref_chain(r, o[1]);
            for (int i = 0; i < a; i++)  r = ref_arith(r, o[0], 1'b0);
        end else begin
            for (int i = 0; i < a; i++)  r = ref_arith(r, o[0], 1'b1);
            for (int i = 0; i < xr; i++) r = ref_chain(r, o[1]);
        end
        return r;
    endfunction

    task automatic run_vec(input logic [N-1:0] b, input bit dec, input logic [1:0] o,
                           input int m, input int a, input bit noise, input string tag,
                           output logic [N-1:0] got);
        logic [N-1:0] exp = ref_cipher(b, dec, o, m, a);
        int p = chain_runs(dec, m) + a;
        @(negedge clk);
        blk = b; mode = dec; opt = o; xc = XW'(m); ac = AW'(a); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        blk = ~b; mode = ~dec; opt = ~o; xc = XW'($urandom); ac = AW'($urandom);
        start = noise;
        for (int k = 1; k <= p + 1; k++) begin
            @(posedge clk);
            @(negedge clk);
            // R6: done only at edge P+1; R8: busy starts leave it there
            chk("R6/R8 done timing", N'(done), N'(k == p + 1));
            if (k == p + 1) chk(tag, res, exp);
            blk = N'({$urandom, $urandom});
            start = noise && (k <= p);
        end
        start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R7 hold result", res, exp);
        chk("R6 single pulse", N'(done), '0);
        got = res;
    endtask

    initial begin
        #(10 * 150000);
        fails++;
        $display("FAIL R6 watchdog actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [N-1:0] ct, pt, orig;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R7 reset state
        chk("R7 reset out", res, '0);
        chk("R7 reset done", N'(done), '0);

        // R10 vector on the 8-bit instance
        @(negedge clk);
        blk8 = 8'h59; xc8 = 3'd3; s8 = 1'b1;
        @(posedge clk);
        @(negedge clk);
        s8 = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 no early done", N'(done8), '0);
        @(posedge clk);
        @(negedge clk);
        chk("R10 done", N'(done8), 1);
        chk("R10 vector", N'(res8), N'(8'h5B));

        // R9 zero counts
        orig = 64'h0123_4567_89AB_CDEF;
        run_vec(orig, 1'b0, 2'b00, 0, 0, 1'b0, "R9 both zero", ct);
        chk("R9 passthrough", ct, orig);
        run_vec(orig, 1'b0, 2'b01, 0, 5, 1'b0, "R9 chain skipped", ct);
        run_vec(orig, 1'b1, 2'b10, 0, 4, 1'b0, "R9 dec no chain", ct);
        run_vec(orig, 1'b0, 2'b10, 7, 0, 1'b0, "R9 arith skipped", ct);

        // R1 R2 single passes
        run_vec(64'h8000_0000_0000_0001, 1'b0, 2'b00, 1, 0, 1'b0, "R1 fwd pass", ct);
        run_vec(64'h8000_0000_0000_0001, 1'b0, 2'b10, 1, 0, 1'b0, "R2 bwd pass", ct);
        // R3 one addition each direction, with carry wrap
        run_vec(64'hFFFF_FFFF_0000_0002, 1'b0, 2'b00, 0, 1, 1'b0, "R3 fwd add", ct);
        run_vec(64'h0000_0003_FFFF_FFFF, 1'b0, 2'b01, 0, 1, 1'b0, "R3 bwd add", ct);

        // R4 R5 round trips on all options, some with busy-time starts (R8)
        for (int o = 0; o < 4; o++) begin
            for (int t = 0; t < 5; t++) begin
                int m = (t == 0) ? 63 : int'($urandom_range(0, 63));
                int a = (t == 0) ? 255 : int'($urandom_range(0, 40));
                orig = {$urandom, $urandom};
                run_vec(orig, 1'b0, 2'(o), m, a, t[0], "R3/R5 encrypt", ct);
                run_vec(ct, 1'b1, 2'(o), m, a, t[1], "R4/R5 decrypt", pt);
                chk("R4 round trip", pt, orig);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule